// File: doc/BRIEF.md
# Page and Region Lock Arbiter

This block decides, in one cycle, whether each of several page-management requesters may take the locks its operation needs. A lock-taking operation (page-add, or the extend/initialize measurement group) needs sole ownership of its target page and must be the only member of that group working on its region. Maintenance operations (accept, accept-copy, permission or type change, tracking) lock no page. They only take a bounded shared hold on the region, so they run alongside a page-add on the same page and region.

A refusal is reported in one of two ways. If the target page is already owned and the requester runs as a guest with the virtualization extension enabled, the response is an exit request. The exit request carries a fixed reason, a qualification byte that holds the page-conflict code with a zero error field, and the requester's linear address. Every other refusal is a plain protection fault. Release ports, one per requester, free what was taken. A release that does not match a held lock changes nothing and sets a sticky error flag.

Top module: `page_lock_arbiter`

## Requirements
- R1: A granted page-add (op 0) or measurement (op 1) request owns its target page, and holds its region exclusively against ops 0 and 1, until a matching release from the same port. Any op 0/1 request on that page in the meantime is refused.
- R2: A maintenance request (op 2) takes no page lock and ignores a region's exclusive hold. It is granted while a page-add holds the same page and region.
- R3: An op 0/1 request whose page is free but whose region is held exclusively is refused with a fault (code 1), even in guest mode with the extension enabled.
- R4: An op 0/1 request whose page is owned is refused. When guest_mode and virt_ext_en are both high, the refusal is an exit (code 2) with reason 8'h3C, qualification 8'h10 (code 1 in the upper nibble, error 0 in the lower), and rsp_addr equal to the request's address. Otherwise the refusal is a fault (code 1). Reason, qualification and address read zero for every response other than an exit.
- R5: Requests in the same cycle are decided in index order, lowest first. A later request sees the locks granted to earlier ones and gets the matching refusal.
- R6: Each request yields exactly one response on its own port one cycle later: code 0 grant, 1 fault, 2 exit. No request means rsp_valid stays low.
- R7: A region grants at most CNT_MAX (default 2) concurrent maintenance holds. Further op 2 requests get a fault until a hold is released with an op 2 release.
- R8: The following releases are ignored: an op 0/1 release whose page is not owned by the releasing port or whose region is not exclusively held, an op 2 release of a region with no shared holds, and any op 3 release. Each of them sets bad_release, which stays high until reset.
- R9: Op code 3 is reserved. It is refused with a fault and leaves every lock unchanged.
- R10: After reset every lock is free, rsp_valid is low and bad_release is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guest_mode | input | 1 | Requesters run in guest mode |
| virt_ext_en | input | 1 | Virtualization extension enabled |
| req_valid | input | NREQ | Acquire request per requester |
| req_op | input | NREQ*2 | Operation class per requester |
| req_page | input | NREQ*PW | Target page index |
| req_region | input | NREQ*RW | Region index |
| req_addr | input | NREQ*AW | Linear address echoed on an exit |
| rel_valid | input | NREQ | Release request per port |
| rel_op | input | NREQ*2 | Class of the lock being released |
| rel_page | input | NREQ*PW | Page being released |
| rel_region | input | NREQ*RW | Region being released |
| rsp_valid | output | NREQ | Response present |
| rsp_code | output | NREQ*2 | Grant, fault or exit |
| rsp_reason | output | NREQ*8 | Exit reason |
| rsp_qual | output | NREQ*8 | Exit qualification and error |
| rsp_addr | output | NREQ*AW | Exit linear address |
| bad_release | output | 1 | Sticky bad-release flag |

## Verification
The assertions assume that page and region indices on the request and release buses are always in range, and that guest_mode and virt_ext_en change only between clock edges. The bench drives every input just after the falling edge and uses only indices below PAGES and REGIONS, so both assumptions hold. The bench also sends releases only when it means them to be rejected or accepted, which keeps the sticky flag's history known at every check.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

   localparam int OPW  = 2;
   localparam int RESW = 2;

   typedef enum logic [OPW-1:0] {
      OP_ADD     = 2'd0,
      OP_MEASURE = 2'd1,
      OP_MAINT   = 2'd2,
      OP_RSVD    = 2'd3
   } op_e;

   typedef enum logic [RESW-1:0] {
      RES_GRANT = 2'd0,
      RES_FAULT = 2'd1,
      RES_EXIT  = 2'd2,
      RES_NONE  = 2'd3
   } res_e;

   function automatic logic locks_page(input logic [OPW-1:0] op);
      return (op == OP_ADD) || (op == OP_MEASURE);
   endfunction

endpackage

// File: rtl/lockarb_decide.sv
module lockarb_decide
   import lockarb_pkg::*;
#(
   parameter int NREQ    = 3,
   parameter int PAGES   = 16,
   parameter int REGIONS = 4,
   parameter int CNT_MAX = 2,
   parameter int PW      = 4,
   parameter int RW      = 2,
   parameter int CW      = 2
) (
   input  logic [NREQ-1:0]                req_v,
   input  logic [NREQ-1:0][OPW-1:0]       req_op,
   input  logic [NREQ-1:0][PW-1:0]        req_page,
   input  logic [NREQ-1:0][RW-1:0]        req_reg,
   input  logic [PAGES-1:0]               page_busy,
   input  logic [REGIONS-1:0]             reg_excl,
   input  logic [REGIONS-1:0][CW-1:0]     reg_cnt,
   input  logic                           exit_en,
   output logic [NREQ-1:0][RESW-1:0]      res,
   output logic [NREQ-1:0]                take_lock,
   output logic [NREQ-1:0]                take_shr
);

   // Requests are walked in index order over a shadow copy of the lock
   // state, so each one sees what lower indices took this cycle.
   always_comb begin
      logic [PAGES-1:0]           sh_busy;
      logic [REGIONS-1:0]         sh_excl;
      logic [REGIONS-1:0][CW-1:0] sh_cnt;
      sh_busy   = page_busy;
      sh_excl   = reg_excl;
      sh_cnt    = reg_cnt;
      take_lock = '0;
      take_shr  = '0;
      for (int i = 0; i < NREQ; i++) begin
         res[i] = RES_NONE;
         if (req_v[i]) begin
            unique case (req_op[i])
               OP_ADD, OP_MEASURE: begin
                  if (sh_busy[req_page[i]]) begin
                     res[i] = exit_en ? RES_EXIT : RES_FAULT;
                  end else if (sh_excl[req_reg[i]]) begin
                     res[i] = RES_FAULT;
                  end else begin
                     res[i]                = RES_GRANT;
                     take_lock[i]          = 1'b1;
                     sh_busy[req_page[i]]  = 1'b1;
                     sh_excl[req_reg[i]]   = 1'b1;
                  end
               end
               OP_MAINT: begin
                  if (sh_cnt[req_reg[i]] >= CW'(CNT_MAX)) begin
                     res[i] = RES_FAULT;
                  end else begin
                     res[i]              = RES_GRANT;
                     take_shr[i]         = 1'b1;
                     sh_cnt[req_reg[i]]  = sh_cnt[req_reg[i]] + 1'b1;
                  end
               end
               default: res[i] = RES_FAULT;
            endcase
         end
      end
   end

endmodule

// File: rtl/lockarb_release.sv
module lockarb_release
   import lockarb_pkg::*;
#(
   parameter int NREQ    = 3,
   parameter int PAGES   = 16,
   parameter int REGIONS = 4,
   parameter int PW      = 4,
   parameter int RW      = 2,
   parameter int CW      = 2,
   parameter int IW      = 2
) (
   input  logic [NREQ-1:0]               rel_v,
   input  logic [NREQ-1:0][OPW-1:0]      rel_op,
   input  logic [NREQ-1:0][PW-1:0]       rel_page,
   input  logic [NREQ-1:0][RW-1:0]       rel_reg,
   input  logic [PAGES-1:0]              page_busy,
   input  logic [PAGES-1:0][IW-1:0]      page_owner,
   input  logic [REGIONS-1:0]            reg_excl,
   input  logic [REGIONS-1:0][CW-1:0]    reg_cnt,
   output logic [NREQ-1:0]               drop_lock,
   output logic [NREQ-1:0]               drop_shr,
   output logic                          bad_any
);

   always_comb begin
      logic [PAGES-1:0]           sh_busy;
      logic [REGIONS-1:0]         sh_excl;
      logic [REGIONS-1:0][CW-1:0] sh_cnt;
      sh_busy   = page_busy;
      sh_excl   = reg_excl;
      sh_cnt    = reg_cnt;
      drop_lock = '0;
      drop_shr  = '0;
      bad_any   = 1'b0;
      for (int i = 0; i < NREQ; i++) begin
         if (rel_v[i]) begin
            unique case (rel_op[i])
               OP_ADD, OP_MEASURE: begin
                  if (sh_busy[rel_page[i]] && (page_owner[rel_page[i]] == IW'(i))
                      && sh_excl[rel_reg[i]]) begin
                     drop_lock[i]          = 1'b1;
                     sh_busy[rel_page[i]]  = 1'b0;
                     sh_excl[rel_reg[i]]   = 1'b0;
                  end else begin
                     bad_any = 1'b1;
                  end
               end
               OP_MAINT: begin
                  if (sh_cnt[rel_reg[i]] != '0) begin
                     drop_shr[i]         = 1'b1;
                     sh_cnt[rel_reg[i]]  = sh_cnt[rel_reg[i]] - 1'b1;
                  end else begin
                     bad_any = 1'b1;
                  end
               end
               default: bad_any = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/lockarb_pages.sv
module lockarb_pages #(
   parameter int NREQ  = 3,
   parameter int PAGES = 16,
   parameter int PW    = 4,
   parameter int IW    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREQ-1:0]             take,
   input  logic [NREQ-1:0][PW-1:0]     take_page,
   input  logic [NREQ-1:0]             drop,
   input  logic [NREQ-1:0][PW-1:0]     drop_page,
   output logic [PAGES-1:0]            busy,
   output logic [PAGES-1:0][IW-1:0]    owner
);

   logic [PAGES-1:0] take_hit;

   always_comb begin
      take_hit = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (take[i]) take_hit[take_page[i]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= '0;
         owner <= '0;
      end else begin
         for (int i = 0; i < NREQ; i++) begin
            if (drop[i]) busy[drop_page[i]] <= 1'b0;
         end
         for (int i = 0; i < NREQ; i++) begin
            if (take[i]) begin
               busy[take_page[i]]  <= 1'b1;
               owner[take_page[i]] <= IW'(i);
            end
         end
      end
   end

   // R1: the decision stage never hands out a page that is already owned
   a_r1_no_double_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hit & busy) == '0);

endmodule

// File: rtl/lockarb_regions.sv
module lockarb_regions #(
   parameter int NREQ    = 3,
   parameter int REGIONS = 4,
   parameter int CNT_MAX = 2,
   parameter int RW      = 2,
   parameter int CW      = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NREQ-1:0]               set_excl,
   input  logic [NREQ-1:0][RW-1:0]       set_reg,
   input  logic [NREQ-1:0]               clr_excl,
   input  logic [NREQ-1:0][RW-1:0]       clr_reg,
   input  logic [NREQ-1:0]               inc_shr,
   input  logic [NREQ-1:0]               dec_shr,
   output logic [REGIONS-1:0]            excl,
   output logic [REGIONS-1:0][CW-1:0]    cnt
);

   logic [REGIONS-1:0][CW-1:0] cnt_n;

   always_comb begin
      for (int r = 0; r < REGIONS; r++) begin
         int up;
         int down;
         up   = 0;
         down = 0;
         for (int i = 0; i < NREQ; i++) begin
            if (inc_shr[i] && (set_reg[i] == RW'(r))) up++;
            if (dec_shr[i] && (clr_reg[i] == RW'(r))) down++;
         end
         cnt_n[r] = CW'(int'(cnt[r]) + up - down);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         excl <= '0;
         cnt  <= '0;
      end else begin
         cnt <= cnt_n;
         for (int i = 0; i < NREQ; i++) begin
            if (clr_excl[i]) excl[clr_reg[i]] <= 1'b0;
         end
         for (int i = 0; i < NREQ; i++) begin
            if (set_excl[i]) excl[set_reg[i]] <= 1'b1;
         end
      end
   end

   generate
      for (genvar r = 0; r < REGIONS; r++) begin : g_cap
         // R7: shared holders never exceed the configured cap
         a_r7_shared_cap: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[r] <= CW'(CNT_MAX));
      end
   endgenerate

endmodule

// File: rtl/page_lock_arbiter.sv
module page_lock_arbiter
   import lockarb_pkg::*;
#(
   parameter int         NREQ        = 3,
   parameter int         PAGES       = 16,
   parameter int         REGIONS     = 4,
   parameter int         CNT_MAX     = 2,
   parameter int         AW          = 16,
   parameter logic [7:0] EXIT_REASON = 8'h3C,
   parameter logic [7:0] QUAL_PAGE   = 8'h10,
   localparam int        PW          = $clog2(PAGES),
   localparam int        RW          = $clog2(REGIONS),
   localparam int        CW          = $clog2(CNT_MAX + 1),
   localparam int        IW          = $clog2(NREQ)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  guest_mode,
   input  logic                  virt_ext_en,
   input  logic [NREQ-1:0]       req_valid,
   input  logic [NREQ*OPW-1:0]   req_op,
   input  logic [NREQ*PW-1:0]    req_page,
   input  logic [NREQ*RW-1:0]    req_region,
   input  logic [NREQ*AW-1:0]    req_addr,
   input  logic [NREQ-1:0]       rel_valid,
   input  logic [NREQ*OPW-1:0]   rel_op,
   input  logic [NREQ*PW-1:0]    rel_page,
   input  logic [NREQ*RW-1:0]    rel_region,
   output logic [NREQ-1:0]       rsp_valid,
   output logic [NREQ*RESW-1:0]  rsp_code,
   output logic [NREQ*8-1:0]     rsp_reason,
   output logic [NREQ*8-1:0]     rsp_qual,
   output logic [NREQ*AW-1:0]    rsp_addr,
   output logic                  bad_release
);

   generate
      if (NREQ < 2)                 $error("NREQ must be at least 2");
      if ((1 << PW) != PAGES)       $error("PAGES must be a power of two");
      if ((1 << RW) != REGIONS)     $error("REGIONS must be a power of two");
      if (REGIONS < 2)              $error("REGIONS must be at least 2");
      if (CNT_MAX < 1)              $error("CNT_MAX must be at least 1");
   endgenerate

   logic [NREQ-1:0][OPW-1:0]   q_op, r_op;
   logic [NREQ-1:0][PW-1:0]    q_page, r_page;
   logic [NREQ-1:0][RW-1:0]    q_reg, r_reg;
   logic [NREQ-1:0][AW-1:0]    q_addr;

   assign q_op   = req_op;
   assign q_page = req_page;
   assign q_reg  = req_region;
   assign q_addr = req_addr;
   assign r_op   = rel_op;
   assign r_page = rel_page;
   assign r_reg  = rel_region;

   logic [PAGES-1:0]            page_busy;
   logic [PAGES-1:0][IW-1:0]    page_owner;
   logic [REGIONS-1:0]          reg_excl;
   logic [REGIONS-1:0][CW-1:0]  reg_cnt;
   logic [NREQ-1:0][RESW-1:0]   res;
   logic [NREQ-1:0]             take_lock, take_shr, drop_lock, drop_shr;
   logic                        bad_now;

   lockarb_decide #(
      .NREQ(NREQ), .PAGES(PAGES), .REGIONS(REGIONS), .CNT_MAX(CNT_MAX),
      .PW(PW), .RW(RW), .CW(CW)
   ) u_decide (
      .req_v     (req_valid),
      .req_op    (q_op),
      .req_page  (q_page),
      .req_reg   (q_reg),
      .page_busy (page_busy),
      .reg_excl  (reg_excl),
      .reg_cnt   (reg_cnt),
      .exit_en   (guest_mode & virt_ext_en),
      .res       (res),
      .take_lock (take_lock),
      .take_shr  (take_shr)
   );

   lockarb_release #(
      .NREQ(NREQ), .PAGES(PAGES), .REGIONS(REGIONS),
      .PW(PW), .RW(RW), .CW(CW), .IW(IW)
   ) u_release (
      .rel_v      (rel_valid),
      .rel_op     (r_op),
      .rel_page   (r_page),
      .rel_reg    (r_reg),
      .page_busy  (page_busy),
      .page_owner (page_owner),
      .reg_excl   (reg_excl),
      .reg_cnt    (reg_cnt),
      .drop_lock  (drop_lock),
      .drop_shr   (drop_shr),
      .bad_any    (bad_now)
   );

   lockarb_pages #(
      .NREQ(NREQ), .PAGES(PAGES), .PW(PW), .IW(IW)
   ) u_pages (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take_lock),
      .take_page (q_page),
      .drop      (drop_lock),
      .drop_page (r_page),
      .busy      (page_busy),
      .owner     (page_owner)
   );

   lockarb_regions #(
      .NREQ(NREQ), .REGIONS(REGIONS), .CNT_MAX(CNT_MAX), .RW(RW), .CW(CW)
   ) u_regions (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_excl (take_lock),
      .set_reg  (q_reg),
      .clr_excl (drop_lock),
      .clr_reg  (r_reg),
      .inc_shr  (take_shr),
      .dec_shr  (drop_shr),
      .excl     (reg_excl),
      .cnt      (reg_cnt)
   );

   logic [NREQ-1:0][RESW-1:0] code_q;
   logic [NREQ-1:0][7:0]      reason_q, qual_q;
   logic [NREQ-1:0][AW-1:0]   addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= '0;
         code_q      <= '0;
         reason_q    <= '0;
         qual_q      <= '0;
         addr_q      <= '0;
         bad_release <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         for (int i = 0; i < NREQ; i++) begin
            code_q[i]   <= res[i];
            reason_q[i] <= (res[i] == RES_EXIT) ? EXIT_REASON : 8'h00;
            qual_q[i]   <= (res[i] == RES_EXIT) ? QUAL_PAGE : 8'h00;
            addr_q[i]   <= (res[i] == RES_EXIT) ? q_addr[i] : '0;
         end
         if (bad_now) bad_release <= 1'b1;
      end
   end

   assign rsp_code   = code_q;
   assign rsp_reason = reason_q;
   assign rsp_qual   = qual_q;
   assign rsp_addr   = addr_q;

   // R8: the error flag, once raised, holds until reset
   a_r8_sticky_error: assert property (@(posedge clk) disable iff (!rst_n)
      bad_release |=> bad_release);

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_rsp_chk
         // R6: a request produces a response on the next cycle
         a_r6_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> rsp_valid[i]);
         // R6: no request, no response
         a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> !rsp_valid[i]);
         // R4: an exit only happens in guest mode with the extension on
         a_r4_exit_needs_guest: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[i] && (code_q[i] == RES_EXIT)) |-> $past(guest_mode && virt_ext_en));
         for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
            // R5: on a same-cycle page clash the higher index cannot also win
            a_r5_lower_wins: assert property (@(posedge clk) disable iff (!rst_n)
               (req_valid[i] && req_valid[j] && locks_page(q_op[i]) && locks_page(q_op[j])
                && (q_page[i] == q_page[j]) && (res[i] == RES_GRANT))
               |-> (res[j] != RES_GRANT));
         end
      end
   endgenerate

endmodule

// File: tb/test_page_lock_arbiter.sv
module test_page_lock_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NREQ = 3;
   localparam int PW   = 4;
   localparam int RW   = 2;
   localparam int AW   = 16;

   localparam logic [1:0] OPA = 2'd0, OPM = 2'd1, OPT = 2'd2, OPR = 2'd3;
   localparam logic [1:0] RG = 2'd0, RF = 2'd1, RX = 2'd2;
   localparam logic [7:0] EXP_REASON = 8'h3C;
   localparam logic [7:0] EXP_QUAL   = 8'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic guest_mode = 1'b0, virt_ext_en = 1'b0;
   logic [NREQ-1:0]      req_valid = '0, rel_valid = '0;
   logic [NREQ*2-1:0]    req_op = '0, rel_op = '0;
   logic [NREQ*PW-1:0]   req_page = '0, rel_page = '0;
   logic [NREQ*RW-1:0]   req_region = '0, rel_region = '0;
   logic [NREQ*AW-1:0]   req_addr = '0;
   logic [NREQ-1:0]      rsp_valid;
   logic [NREQ*2-1:0]    rsp_code;
   logic [NREQ*8-1:0]    rsp_reason, rsp_qual;
   logic [NREQ*AW-1:0]   rsp_addr;
   logic                 bad_release;

   page_lock_arbiter i_page_lock_arbiter (
      .clk(clk), .rst_n(rst_n), .guest_mode(guest_mode), .virt_ext_en(virt_ext_en),
      .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
      .req_region(req_region), .req_addr(req_addr),
      .rel_valid(rel_valid), .rel_op(rel_op), .rel_page(rel_page), .rel_region(rel_region),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_reason(rsp_reason),
      .rsp_qual(rsp_qual), .rsp_addr(rsp_addr), .bad_release(bad_release)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          idx;
      logic [1:0]  code;
      logic [7:0]  reason;
      logic [7:0]  qual;
      logic [15:0] addr;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic expect_rsp(input int idx, input logic [1:0] code,
                             input logic [15:0] addr, input string tag);
      exp_t e;
      e.idx    = idx;
      e.code   = code;
      e.reason = (code == RX) ? EXP_REASON : 8'h00;
      e.qual   = (code == RX) ? EXP_QUAL : 8'h00;
      e.addr   = (code == RX) ? addr : 16'h0000;
      e.tag    = tag;
      sb.push_back(e);
   endtask

   task automatic set_req(input int idx, input logic [1:0] op, input int pg,
                          input int rg, input logic [15:0] addr);
      req_valid[idx]          = 1'b1;
      req_op[idx*2 +: 2]      = op;
      req_page[idx*PW +: PW]  = PW'(pg);
      req_region[idx*RW +: RW] = RW'(rg);
      req_addr[idx*AW +: AW]  = addr;
   endtask

   task automatic set_rel(input int idx, input logic [1:0] op, input int pg, input int rg);
      rel_valid[idx]           = 1'b1;
      rel_op[idx*2 +: 2]       = op;
      rel_page[idx*PW +: PW]   = PW'(pg);
      rel_region[idx*RW +: RW] = RW'(rg);
   endtask

   task automatic next_cycle();
      @(negedge clk);
      req_valid = '0;
      rel_valid = '0;
   endtask

   // Monitor: compare every response against the scoreboard
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         for (int i = 0; i < NREQ; i++) begin
            if (rsp_valid[i]) begin
               if (sb.size() == 0) begin
                  n_cmp++;
                  n_bad++;
                  $display("FAIL R6 unexpected response on port %0d: actual 1 expected 0", i);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(e.tag, "port", 32'(i), 32'(e.idx));
                  check(e.tag, "code", 32'(rsp_code[i*2 +: 2]), 32'(e.code));
                  check(e.tag, "reason", 32'(rsp_reason[i*8 +: 8]), 32'(e.reason));
                  check(e.tag, "qual", 32'(rsp_qual[i*8 +: 8]), 32'(e.qual));
                  check(e.tag, "addr", 32'(rsp_addr[i*AW +: AW]), 32'(e.addr));
               end
            end
         end
         while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            n_bad++;
            $display("FAIL %s missing response on port %0d: actual 0 expected 1", e.tag, e.idx);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
      check("R10", "bad_release in reset", 32'(bad_release), 32'h0);
      rst_n = 1'b1;

      // R1: take page 3 / region 1
      next_cycle(); set_req(0, OPA, 3, 1, 16'h1000); expect_rsp(0, RG, 16'h0, "R1");
      // R4: owned page, host mode -> fault
      next_cycle(); set_req(1, OPA, 3, 2, 16'h2000); expect_rsp(1, RF, 16'h0, "R4");
      // R4: owned page, guest + extension -> exit with address
      next_cycle(); guest_mode = 1; virt_ext_en = 1;
      set_req(2, OPA, 3, 2, 16'hABC0); expect_rsp(2, RX, 16'hABC0, "R4");
      // R4: guest without extension -> fault
      next_cycle(); virt_ext_en = 0;
      set_req(1, OPA, 3, 2, 16'h2100); expect_rsp(1, RF, 16'h0, "R4");
      // R3: region conflict in guest + extension is still a fault
      next_cycle(); virt_ext_en = 1;
      set_req(1, OPM, 5, 1, 16'h5000); expect_rsp(1, RF, 16'h0, "R3");
      // R2: maintenance shares page 3 and region 1 with the add
      next_cycle(); guest_mode = 0; virt_ext_en = 0;
      set_req(1, OPT, 3, 1, 16'h0); expect_rsp(1, RG, 16'h0, "R2");
      set_req(2, OPT, 3, 1, 16'h0); expect_rsp(2, RG, 16'h0, "R2");
      // R7: third shared hold on region 1 refused
      next_cycle(); set_req(0, OPT, 0, 1, 16'h0); expect_rsp(0, RF, 16'h0, "R7");
      // R5: same-cycle clash, lowest index wins
      next_cycle(); guest_mode = 1; virt_ext_en = 1;
      set_req(0, OPA, 7, 2, 16'h7000); expect_rsp(0, RG, 16'h0, "R5");
      set_req(1, OPA, 7, 3, 16'h7100); expect_rsp(1, RX, 16'h7100, "R5");
      set_req(2, OPA, 8, 2, 16'h8000); expect_rsp(2, RF, 16'h0, "R5");
      // R8: bad release by a port that does not own page 3
      next_cycle(); guest_mode = 0; virt_ext_en = 0;
      check("R8", "bad_release before misuse", 32'(bad_release), 32'h0);
      set_rel(1, OPA, 3, 1);
      next_cycle();
      check("R8", "bad_release after misuse", 32'(bad_release), 32'h1);
      set_req(2, OPA, 3, 0, 16'h0); expect_rsp(2, RF, 16'h0, "R8");
      // R1: proper release by the owner frees page 3 and region 1
      next_cycle(); set_rel(0, OPA, 3, 1);
      next_cycle(); set_req(2, OPA, 3, 1, 16'h0); expect_rsp(2, RG, 16'h0, "R1");
      // R7: freeing one shared hold makes room for exactly one more
      next_cycle(); set_rel(1, OPT, 0, 1);
      next_cycle(); set_req(0, OPT, 0, 1, 16'h0); expect_rsp(0, RG, 16'h0, "R7");
      next_cycle(); set_req(0, OPT, 0, 1, 16'h0); expect_rsp(0, RF, 16'h0, "R7");
      // R9: reserved op refused, page 9 / region 3 stay free
      next_cycle(); set_req(0, OPR, 9, 3, 16'h9000); expect_rsp(0, RF, 16'h0, "R9");
      next_cycle(); set_req(1, OPA, 9, 3, 16'h0); expect_rsp(1, RG, 16'h0, "R9");
      // R1 with measurement op, R5 same-cycle page clash in host mode
      next_cycle();
      set_req(0, OPM, 10, 0, 16'h0); expect_rsp(0, RG, 16'h0, "R1");
      set_req(1, OPA, 10, 2, 16'h0); expect_rsp(1, RF, 16'h0, "R5");
      // R6: idle cycle yields nothing; R8 flag still held
      next_cycle();
      next_cycle();
      check("R8", "bad_release sticky", 32'(bad_release), 32'h1);
      next_cycle();
      next_cycle();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule